// File: doc/BRIEF.md
# Servo Position Pulse Generator

This block drives the control line of a hobby position servo. A position command is turned into a periodic high pulse. The length of that pulse, not the ratio of high time to low time, tells the servo which shaft angle to hold. The shortest pulse, 920 µs, sends the shaft fully counterclockwise. The longest, 2120 µs, sends it fully clockwise. A 1520 µs pulse holds it at centre. Between the two ends the shaft covers 180 degrees.

An 8-bit command maps linearly onto that width range. A one-cycle load strobe hands a command to the block. The block holds the newest command and applies it only at the start of the next frame. As a result, a pulse that is already high is never cut short or stretched. Frames repeat on a fixed period built from a microsecond tick, and the tick is divided down from the system clock.

After reset the line stays low for one whole frame. It then sends centre pulses until the first command is loaded.

Top module: `servo_pulse_gen`

## Requirements
- R1: While reset is asserted, and from reset release until the first frame boundary, `pulse_o` is low. The first rising edge comes no earlier than (FRAME_US-1)*CLKS_PER_US cycles and no later than FRAME_US*CLKS_PER_US+4 cycles after release.
- R2: Every pulse starts at a frame boundary. Consecutive rising edges of `pulse_o` are exactly FRAME_US*CLKS_PER_US clock cycles apart.
- R3: For a loaded command c, the pulse stays high for exactly (MIN_US + floor(c*(MAX_US-MIN_US)/255))*CLKS_PER_US cycles. With the defaults, c=0 gives 920 µs and c=255 gives 2120 µs.
- R4: Until the first load, every pulse is (MIN_US+MAX_US)/2 µs wide, which is 1520 µs by default.
- R5: A load takes effect at the next frame boundary. A pulse that is high when a load arrives keeps the width it started with.
- R6: When several loads arrive within one frame, only the last one sets the next pulse.
- R7: While `load_i` is low, changes on `cmd_i` have no effect on any pulse width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 8 | Position command, 0 = full counterclockwise, 255 = full clockwise |
| load_i | input | 1 | One-cycle strobe that captures `cmd_i` |
| pulse_o | output | 1 | Servo control line |

## Verification
The hardest case to reach from the ports is a load that arrives while a pulse is already high. The new width must wait for the next frame, and the running pulse must end at its original length. The stimulus waits for a rising edge on `pulse_o`, counts a fixed number of cycles into the pulse, and strobes a very different command. It then measures both the interrupted pulse and the one that follows. Other directed cases cover the two end commands, a command change with no strobe, and two strobes in one frame. Seeded random commands fill in the middle of the width range.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned CMD_FULL = (1 << CMD_W) - 1;
  typedef logic [CMD_W-1:0] pos_cmd_t;
endpackage

// File: rtl/servo_rst_sync.sv
module servo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == CW'(DIV - 1));

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o = wrap;
    end
  endgenerate
endmodule

// File: rtl/servo_width_map.sv
module servo_width_map
  import servo_pkg::*;
#(
  parameter int unsigned MIN_US = 920,
  parameter int unsigned MAX_US = 2120,
  parameter int unsigned TW     = 15
) (
  input  pos_cmd_t      cmd_i,
  output logic [TW-1:0] width_o
);
  localparam int unsigned SPAN = MAX_US - MIN_US;

  logic [31:0] scaled;

  always_comb begin
    scaled  = (32'(cmd_i) * 32'(SPAN)) / 32'(CMD_FULL);
    width_o = TW'(32'(MIN_US) + scaled);
  end
endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer #(
  parameter int unsigned FRAME_US = 20000,
  parameter int unsigned TW       = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] pend_w_i,
  output logic [TW-1:0] frame_cnt_o,
  output logic [TW-1:0] active_w_o,
  output logic          started_o,
  output logic          pulse_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] act_q, act_d;
  logic          run_q, run_d;
  logic          pls_q, pls_d;
  logic          boundary;

  assign boundary = tick_i && (cnt_q == TW'(FRAME_US - 1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    run_d = run_q;
    if (boundary) begin
      cnt_d = '0;
      act_d = pend_w_i;
      run_d = 1'b1;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    pls_d = run_d && (cnt_d < act_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      run_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      run_q <= run_d;
      pls_q <= pls_d;
    end
  end

  assign frame_cnt_o = cnt_q;
  assign active_w_o  = act_q;
  assign started_o   = run_q;
  assign pulse_o     = pls_q;
endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 100,
  parameter int unsigned FRAME_US    = 20000,
  parameter int unsigned MIN_US      = 920,
  parameter int unsigned MAX_US      = 2120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic       load_i,
  output logic       pulse_o
);
  localparam int unsigned TW     = $clog2(FRAME_US + 1);
  localparam int unsigned CENTRE = (MIN_US + MAX_US) / 2;

  logic          rst_n_s;
  logic          tick;
  logic [TW-1:0] mapped_w;
  logic [TW-1:0] pend_w_q, pend_w_d;
  logic [TW-1:0] frame_cnt;
  logic [TW-1:0] active_w;
  logic          started;

  servo_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  servo_tick_gen #(.DIV(CLKS_PER_US)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .tick_o (tick)
  );

  servo_width_map #(.MIN_US(MIN_US), .MAX_US(MAX_US), .TW(TW)) u_map (
    .cmd_i   (pos_cmd_t'(cmd_i)),
    .width_o (mapped_w)
  );

  always_comb begin
    pend_w_d = pend_w_q;
    if (load_i) pend_w_d = mapped_w;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) pend_w_q <= TW'(CENTRE);
    else          pend_w_q <= pend_w_d;
  end

  servo_frame_timer #(.FRAME_US(FRAME_US), .TW(TW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .tick_i      (tick),
    .pend_w_i    (pend_w_q),
    .frame_cnt_o (frame_cnt),
    .active_w_o  (active_w),
    .started_o   (started),
    .pulse_o     (pulse_o)
  );
endmodule

// File: rtl/servo_pulse_chk.sv
module servo_pulse_chk #(
  parameter int unsigned FRAME_US = 20000,
  parameter int unsigned MIN_US   = 920,
  parameter int unsigned MAX_US   = 2120,
  parameter int unsigned TW       = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          pulse_i,
  input logic          started_i,
  input logic [TW-1:0] frame_cnt_i,
  input logic [TW-1:0] active_w_i,
  input logic [TW-1:0] pend_w_i
);
  p_low_before_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> started_i);

  p_rise_at_frame_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> (frame_cnt_i == '0));

  p_count_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt_i < TW'(FRAME_US));

  p_count_waits_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(frame_cnt_i));

  p_pending_in_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w_i >= TW'(MIN_US)) && (pend_w_i <= TW'(MAX_US)));

  p_width_held_in_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && $past(pulse_i)) |-> $stable(active_w_i));
endmodule

bind servo_pulse_gen servo_pulse_chk #(
  .FRAME_US (FRAME_US),
  .MIN_US   (MIN_US),
  .MAX_US   (MAX_US),
  .TW       (TW)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_s),
  .tick_i      (tick),
  .pulse_i     (pulse_o),
  .started_i   (started),
  .frame_cnt_i (frame_cnt),
  .active_w_i  (active_w),
  .pend_w_i    (pend_w_q)
);

// File: tb/servo_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module servo_pulse_gen_tb_top;
  localparam int CPU   = 2;
  localparam int FRM   = 3000;
  localparam int MINU  = 920;
  localparam int MAXU  = 2120;
  localparam int FRAME_CYC = FRM * CPU;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] cmd_i;
  logic       load_i;
  logic       pulse_o;

  int    checks   = 0;
  int    failures = 0;
  longint cyc     = 0;
  longint last_rise = -1;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  servo_pulse_gen #(
    .CLKS_PER_US (CPU),
    .FRAME_US    (FRM),
    .MIN_US      (MINU),
    .MAX_US      (MAXU)
  ) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_i),
    .load_i  (load_i),
    .pulse_o (pulse_o)
  );

  function automatic int exp_cycles(input int c);
    return (MINU + (c * (MAXU - MINU)) / 255) * CPU;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int c);
    cmd_i  = 8'(c);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // Wait for a pulse, count its high cycles; optionally strobe a load mid-pulse.
  task automatic measure(output int hi, output longint rise_t,
                         input bit mid_en, input int mid_cmd);
    while (pulse_o !== 1'b1) @(negedge clk_i);
    rise_t = cyc;
    hi = 0;
    while (pulse_o === 1'b1) begin
      if (mid_en && hi == 200) begin
        cmd_i = 8'(mid_cmd);
        load_i = 1'b1;
      end else begin
        load_i = 1'b0;
      end
      hi++;
      @(negedge clk_i);
    end
    load_i = 1'b0;
  endtask

  task automatic frame_check(input string req, input int exp_hi,
                             input bit mid_en, input int mid_cmd);
    int hi;
    longint rt;
    measure(hi, rt, mid_en, mid_cmd);
    check(hi == exp_hi, req, hi, exp_hi);
    if (last_rise >= 0)
      check((rt - last_rise) == FRAME_CYC, "R2", rt - last_rise, FRAME_CYC);
    last_rise = rt;
  endtask

  initial begin
    #(190000 * 10);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint t0;
    rst_ni = 1'b0;
    load_i = 1'b0;
    cmd_i  = 8'd0;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk_i);
    check(pulse_o == 1'b0, "R1", pulse_o, 0);
    rst_ni = 1'b1;
    t0 = cyc;
    while (pulse_o !== 1'b1) @(negedge clk_i);
    check(((cyc - t0) >= (FRM - 1) * CPU) && ((cyc - t0) <= FRAME_CYC + 4),
          "R1", cyc - t0, FRAME_CYC);

    frame_check("R4", (MINU + MAXU) / 2 * CPU, 1'b0, 0);
    frame_check("R4", (MINU + MAXU) / 2 * CPU, 1'b0, 0);

    load(0);
    frame_check("R3", exp_cycles(0), 1'b0, 0);
    load(255);
    frame_check("R3", exp_cycles(255), 1'b0, 0);

    cmd_i = 8'd50;
    @(negedge clk_i);
    frame_check("R7", exp_cycles(255), 1'b0, 0);

    load(10);
    load(200);
    frame_check("R6", exp_cycles(200), 1'b0, 0);

    load(60);
    frame_check("R5", exp_cycles(60), 1'b1, 240);
    frame_check("R5", exp_cycles(240), 1'b0, 0);

    for (int i = 0; i < 6; i++) begin
      int c;
      c = int'($urandom % 256);
      load(c);
      frame_check("R3", exp_cycles(c), 1'b0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule